// File: doc/BRIEF.md
# Scan Chain with Shift-Timing Fault Emulation

This block is a serial scan chain of configurable length whose cells can each be told to misbehave the way a cell with a timing defect does while the chain is shifting. A cell can be healthy. It can be setup-faulty, which means it is too slow and still holds its earlier value when a change reaches it. It can also be hold-faulty, which means it is too fast and shows the value arriving from upstream in the same cycle, as if it were a wire. Any mix of cells may be faulty at once. As data passes through several faulty cells, their effects add up.

The chain has two operating modes, selected by the level of `scan_en`. MODE_SHIFT (high) moves data one cell downstream per clock, from `scan_in` towards `scan_out`. MODE_CAPTURE (low) loads every cell from `capture_in` in parallel, and all faults are ignored. The only transitions are a rise of `scan_en` (capture to shift) and a fall (shift to capture), and both take effect on the same clock edge. The fault setting of each cell is written through a small address/data port, and only while the chain is in MODE_CAPTURE. The block is meant as a device under test for controllers that locate timing faults in scan chains.

Cells are numbered from LEN-1 at the input end down to 0 at the output end, so a higher number is upstream. Cell 0 drives `scan_out`.

Top module: `scan_fault_chain`

## Requirements
- R1: A synchronous active-high `rst` clears every cell to 0 and sets every cell's fault setting to healthy, so `scan_out` is 0 in the cycle after reset.
- R2: In MODE_SHIFT, each healthy cell takes on the value visible at its upstream neighbour (or at `scan_in` for cell LEN-1). On a chain with no faults, a 1 driven at `scan_in` into an all-zero chain appears at `scan_out` after exactly LEN shift edges.
- R3: In MODE_SHIFT, a setup-faulty cell loads the value that was arriving at it one shift edge earlier. Each such cell therefore adds one shift edge of latency. Right after a capture, its first shift keeps the captured value.
- R4: In MODE_SHIFT, a hold-faulty cell shows its incoming value in the same cycle, with no register delay. Each such cell removes one shift edge of latency. This includes cell 0, which then drives `scan_out` straight from cell 1.
- R5: Several faulty cells compound. The latency from `scan_in` to `scan_out` is LEN, plus the number of setup-faulty cells, minus the number of hold-faulty cells. A run of adjacent hold-faulty cells acts as one pass-through path, with no combinational loop.
- R6: In MODE_CAPTURE, every cell loads its `capture_in` bit whatever its fault setting. While `scan_en` stays low, `scan_out` shows the register of cell 0, even when cell 0 is hold-faulty.
- R7: A fault-setting write made while `scan_en` is high is ignored: afterwards the chain behaves as before.
- R8: Fault codes on `cfg_kind` are: 0 = healthy, 1 = setup-faulty, 2 = hold-faulty, 3 = healthy. A write with `cfg_we` high while `scan_en` is low sets cell `cfg_addr` on that clock edge. A write in the same cycle as a capture applies both.
- R9: With every cell hold-faulty and `scan_en` high, `scan_out` follows `scan_in` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = MODE_SHIFT, 0 = MODE_CAPTURE |
| scan_in | input | 1 | Serial data into cell LEN-1 |
| capture_in | input | LEN | Parallel load value, bit i to cell i |
| cfg_we | input | 1 | Fault-setting write strobe |
| cfg_addr | input | AW | Cell number to configure |
| cfg_kind | input | 2 | Fault code (see R8) |
| scan_out | output | 1 | Visible value of cell 0 |

## Verification
Two functions can fall in the same cycle: a fault-setting write and a chain operation. The bench raises `cfg_we` in a cycle where `scan_en` is high, then measures the input-to-output latency, which must be unchanged (write dropped). It also pairs a write with a capture cycle. There `scan_out` must show the captured bit, and the next latency measurement must reflect the new fault setting (both applied).

// File: rtl/scf_pkg.sv
package scf_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_SETUP = 2'd1,
        FK_HOLD  = 2'd2,
        FK_SPARE = 2'd3
    } fault_kind_e;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } chain_mode_e;

endpackage

// File: rtl/scf_cfg_bank.sv
module scf_cfg_bank #(
    parameter int LEN = 8,
    parameter int AW  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  scf_pkg::chain_mode_e mode,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        kind_in,
    output logic [2*LEN-1:0]  kind_flat
);
    import scf_pkg::*;

    for (genvar g = 0; g < LEN; g++) begin : g_slot
        logic [1:0] slot_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_r <= FK_NONE;
            end else if (mode == MODE_CAPTURE && we && addr == AW'(g)) begin
                slot_r <= kind_in;
            end
        end
        assign kind_flat[2*g +: 2] = slot_r;
    end

endmodule

// File: rtl/scf_route.sv
module scf_route #(
    parameter int LEN = 8
) (
    input  scf_pkg::chain_mode_e mode,
    input  logic              serial_in,
    input  logic [LEN-1:0]    cell_q,
    input  logic [2*LEN-1:0]  kind_flat,
    output logic [LEN-1:0]    cell_in,
    output logic              serial_out
);
    import scf_pkg::*;

    // Sweep from the input end downstream; a hold-faulty cell forwards the
    // running value instead of its register, so pass-through runs stay acyclic.
    always_comb begin
        logic carry;
        carry = serial_in;
        cell_in = '0;
        for (int i = LEN - 1; i >= 0; i--) begin
            cell_in[i] = carry;
            if (mode == MODE_SHIFT && fault_kind_e'(kind_flat[2*i +: 2]) == FK_HOLD) begin
                carry = carry;
            end else begin
                carry = cell_q[i];
            end
        end
        serial_out = carry;
    end

endmodule

// File: rtl/scf_cell_array.sv
module scf_cell_array #(
    parameter int LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  scf_pkg::chain_mode_e mode,
    input  logic [LEN-1:0]    cell_in,
    input  logic [LEN-1:0]    cap_in,
    input  logic [2*LEN-1:0]  kind_flat,
    output logic [LEN-1:0]    cell_q
);
    import scf_pkg::*;

    for (genvar g = 0; g < LEN; g++) begin : g_cell
        logic        q_r;
        logic        stage_r;
        fault_kind_e kind;

        assign kind = fault_kind_e'(kind_flat[2*g +: 2]);

        // stage_r holds the value that arrived at the previous shift edge;
        // a setup-faulty cell loads it instead of the fresh arrival.
        always_ff @(posedge clk) begin
            if (rst) begin
                q_r     <= 1'b0;
                stage_r <= 1'b0;
            end else begin
                unique case (mode)
                    MODE_SHIFT: begin
                        stage_r <= cell_in[g];
                        q_r     <= (kind == FK_SETUP) ? stage_r : cell_in[g];
                    end
                    MODE_CAPTURE: begin
                        stage_r <= cap_in[g];
                        q_r     <= cap_in[g];
                    end
                endcase
            end
        end

        assign cell_q[g] = q_r;
    end

endmodule

// File: rtl/scan_fault_chain.sv
module scan_fault_chain #(
    parameter int LEN = 8,
    localparam int AW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           scan_en,
    input  logic           scan_in,
    input  logic [LEN-1:0] capture_in,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [1:0]     cfg_kind,
    output logic           scan_out
);
    import scf_pkg::*;

    chain_mode_e      mode;
    logic [LEN-1:0]   cell_q;
    logic [LEN-1:0]   cell_in;
    logic [2*LEN-1:0] kind_flat;

    assign mode = scan_en ? MODE_SHIFT : MODE_CAPTURE;

    scf_cfg_bank #(.LEN(LEN), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .kind_in   (cfg_kind),
        .kind_flat (kind_flat)
    );

    scf_route #(.LEN(LEN)) u_route (
        .mode       (mode),
        .serial_in  (scan_in),
        .cell_q     (cell_q),
        .kind_flat  (kind_flat),
        .cell_in    (cell_in),
        .serial_out (scan_out)
    );

    scf_cell_array #(.LEN(LEN)) u_cells (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cell_in   (cell_in),
        .cap_in    (capture_in),
        .kind_flat (kind_flat),
        .cell_q    (cell_q)
    );

endmodule

// File: rtl/scf_chk.sv
module scf_chk #(
    parameter int LEN = 8,
    parameter int AW  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             scan_en,
    input logic [LEN-1:0]   capture_in,
    input logic             cfg_we,
    input logic [AW-1:0]    cfg_addr,
    input logic [1:0]       cfg_kind,
    input logic             scan_out,
    input logic [LEN-1:0]   cell_q,
    input logic [LEN-1:0]   cell_in,
    input logic [2*LEN-1:0] kind_flat
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cell_q == '0 && kind_flat == '0 && !scan_out));

    // R6
    capture_loads_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> cell_q == $past(capture_in));

    // R7
    shift_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && cfg_we) |=> $stable(kind_flat));

    for (genvar g = 0; g < LEN; g++) begin : g_chk
        // R2
        healthy_shift_chk: assert property (@(posedge clk) disable iff (rst)
            (scan_en && kind_flat[2*g +: 2] != 2'd1) |=> cell_q[g] == $past(cell_in[g]));

        // R3
        setup_lag_chk: assert property (@(posedge clk) disable iff (rst)
            (scan_en && $past(scan_en) && !$past(rst) && kind_flat[2*g +: 2] == 2'd1)
                |=> cell_q[g] == $past(cell_in[g], 2));

        // R8
        cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
            (!scan_en && cfg_we && cfg_addr == AW'(g)) |=> kind_flat[2*g +: 2] == $past(cfg_kind));
    end

endmodule

bind scan_fault_chain scf_chk #(.LEN(LEN), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_en    (scan_en),
    .capture_in (capture_in),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_kind   (cfg_kind),
    .scan_out   (scan_out),
    .cell_q     (cell_q),
    .cell_in    (cell_in),
    .kind_flat  (kind_flat)
);

// File: tb/tb_scan_fault_chain.sv
module tb_scan_fault_chain;
    localparam int L  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic [L-1:0]  capture_in = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [1:0]    cfg_kind = '0;
    logic          scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic       m_q  [L];
    logic       m_st [L];
    logic [1:0] m_k  [L];

    always #2 clk = ~clk;

    scan_fault_chain #(.LEN(L)) dut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .capture_in(capture_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_kind(cfg_kind), .scan_out(scan_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic vis(input int i, input logic se, input logic up);
        return (se && m_k[i] == 2'd2) ? up : m_q[i];
    endfunction

    function automatic logic model_out(input logic se, input logic si);
        logic up = si;
        for (int i = L - 1; i >= 0; i--) up = vis(i, se, up);
        return up;
    endfunction

    task automatic model_step(input logic se, input logic si, input logic [L-1:0] cap,
                              input logic we, input logic [AW-1:0] a, input logic [1:0] k);
        logic arr [L];
        logic up = si;
        for (int i = L - 1; i >= 0; i--) begin
            arr[i] = up;
            up = vis(i, se, up);
        end
        for (int i = 0; i < L; i++) begin
            if (se) begin
                m_q[i]  = (m_k[i] == 2'd1) ? m_st[i] : arr[i];
                m_st[i] = arr[i];
            end else begin
                m_q[i]  = cap[i];
                m_st[i] = cap[i];
            end
        end
        if (!se && we) m_k[a] = k;
    endtask

    // one clock: drive, compare scan_out with the reference, advance
    task automatic tick(input logic se, input logic si, input logic [L-1:0] cap,
                        input logic we, input logic [AW-1:0] a, input logic [1:0] k,
                        input string tag, output logic seen);
        @(negedge clk);
        scan_en = se; scan_in = si; capture_in = cap;
        cfg_we = we; cfg_addr = a; cfg_kind = k;
        #1;
        seen = scan_out;
        check(tag, int'(scan_out), int'(model_out(se, si)));
        @(posedge clk);
        model_step(se, si, cap, we, a, k);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scan_en = 1'b0; cfg_we = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < L; i++) begin m_q[i] = 0; m_st[i] = 0; m_k[i] = 0; end
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 scan_out after reset", int'(scan_out), 0);
    endtask

    task automatic set_kind(input int a, input logic [1:0] k);
        logic s;
        tick(1'b0, 1'b0, '0, 1'b1, AW'(a), k, "R8 cfg cycle", s);
    endtask

    task automatic clear_kinds();
        for (int i = 0; i < L; i++) set_kind(i, 2'd0);
    endtask

    // zero the chain by capture, then count shift edges until a 1 emerges
    task automatic latency(input int exp, input string tag);
        logic s;
        int got = 3 * L + 1;
        tick(1'b0, 1'b0, '0, 1'b0, '0, '0, tag, s);
        for (int n = 0; n <= 3 * L; n++) begin
            tick(1'b1, 1'b1, '0, 1'b0, '0, '0, tag, s);
            if (s) begin got = n; break; end
        end
        check(tag, got, exp);
    endtask

    task automatic data_run(input logic [L-1:0] cap, input logic [2*L-1:0] pat, input string tag);
        logic s;
        tick(1'b0, 1'b0, cap, 1'b0, '0, '0, tag, s);
        for (int n = 0; n < 2 * L; n++) tick(1'b1, pat[n], '0, 1'b0, '0, '0, tag, s);
    endtask

    task automatic t_healthy();
        do_reset();
        latency(L, "R2 healthy latency");
        data_run(8'b1011_0010, 16'b0011_1100_1010_0110, "R2 healthy data");
    endtask

    task automatic t_setup();
        logic s;
        do_reset();
        set_kind(3, 2'd1);
        latency(L + 1, "R3 setup latency");
        data_run(8'b1010_0110, 16'b1111_1110_0000_0000, "R3 setup data");
        // first shift after capture keeps the captured value in cell 3
        tick(1'b0, 1'b0, 8'b0000_1000, 1'b0, '0, '0, "R3 capture", s);
        for (int n = 0; n < 4; n++) tick(1'b1, 1'b0, '0, 1'b0, '0, '0, "R3 captured hold", s);
        check("R3 captured value surfaces late", int'(s), 1);
    endtask

    task automatic t_hold();
        logic s;
        do_reset();
        set_kind(3, 2'd2);
        latency(L - 1, "R4 hold latency mid");
        clear_kinds();
        set_kind(0, 2'd2);
        latency(L - 1, "R4 hold latency cell0");
        tick(1'b0, 1'b0, 8'b0000_0001, 1'b0, '0, '0, "R6 capture", s);
        tick(1'b0, 1'b0, 8'b0000_0001, 1'b0, '0, '0, "R6 capture", s);
        check("R6 scan_out is cell0 register in capture", int'(s), 1);
        data_run(8'b0110_1001, 16'b0000_0001_1111_1111, "R4 hold data");
    endtask

    task automatic t_multi();
        do_reset();
        set_kind(6, 2'd2);
        set_kind(5, 2'd2);
        set_kind(2, 2'd1);
        latency(L - 1, "R5 two hold one setup latency");
        data_run(8'b1100_0011, 16'b1111_1111_1000_0000, "R5 compound data");
        clear_kinds();
        set_kind(2, 2'd1);
        set_kind(5, 2'd1);
        latency(L + 2, "R5 two setup latency");
        data_run(8'b0101_1010, 16'b0000_0000_0111_1111, "R5 two setup data");
    endtask

    task automatic t_overlap();
        logic s;
        do_reset();
        // write during shift must be dropped
        tick(1'b1, 1'b0, '0, 1'b1, 3'd3, 2'd2, "R7 write during shift", s);
        latency(L, "R7 latency unchanged");
        // write together with capture: both apply
        tick(1'b0, 1'b0, 8'b0000_0001, 1'b1, 3'd3, 2'd2, "R8 write with capture", s);
        tick(1'b0, 1'b0, 8'b0000_0001, 1'b0, '0, '0, "R8 write with capture", s);
        check("R8 captured bit visible", int'(s), 1);
        latency(L - 1, "R8 new setting active");
    endtask

    task automatic t_code3();
        do_reset();
        set_kind(3, 2'd3);
        latency(L, "R8 code 3 is healthy");
    endtask

    task automatic t_all_hold();
        logic s;
        do_reset();
        for (int i = 0; i < L; i++) set_kind(i, 2'd2);
        for (int n = 0; n < 6; n++) begin
            tick(1'b1, logic'(n % 2), '0, 1'b0, '0, '0, "R9 follow", s);
            check("R9 scan_out follows scan_in", int'(s), n % 2);
        end
        // R1: reset in the middle wipes the settings
        do_reset();
        latency(L, "R1 settings cleared");
    endtask

    initial begin
        do_reset();
        t_healthy();
        t_setup();
        t_hold();
        t_multi();
        t_overlap();
        t_code3();
        t_all_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule